// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-cycle core and decides, every cycle, where execution continues. It looks at the instruction word being executed and the two operand values already read from the register file for that instruction, and from them picks one of four successors: the next sequential word, a region-relative absolute jump, a jump to an address held in a register, or a conditional branch relative to the incremented PC. The chosen address is presented combinationally and loaded into the PC register on the next rising clock edge.

For the call form of the absolute jump the block also raises a register-file write request toward the link register and supplies the return address. That return address skips one word beyond the incremented PC, leaving room for the instruction that follows the jump; nothing else here models that slot.

Top module: `next_pc_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) loads 0 into `pc`.
- R2: When the opcode (instr[31:26]) is 0x08 or above, or is 0x00 with funct (instr[5:0]) other than 0x08, the next PC is PC+4, wrapping modulo 2^32 (0xFFFFFFFC advances to 0).
- R3: Opcode 0x02 sets the next PC to {(PC+4)[31:28], instr[25:0], 2'b00}.
- R4: Opcode 0x00 with funct 0x08 sets the next PC to `rs_val`.
- R5: Opcode 0x04 (taken when rs_val equals rt_val) and opcode 0x05 (taken when they differ) set the next PC to PC+4 plus the sign-extended instr[15:0] shifted left by two when taken, and to PC+4 otherwise.
- R6: Opcode 0x01 with instr[20:16] equal to 0 branches when rs_val is negative, with instr[20:16] equal to 1 branches when rs_val is zero or positive, and with any other value there falls through to PC+4; the taken target is formed as in R5.
- R7: Opcode 0x06 branches when signed rs_val is less than or equal to zero, and opcode 0x07 branches when it is greater than zero, with the target formed as in R5.
- R8: Opcode 0x03 jumps exactly as R3 and in the same cycle drives `link_we` high, `link_idx` to 31 and `link_val` to PC+8.
- R9: For every opcode other than 0x03, `link_we`, `link_idx` and `link_val` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word being executed |
| rs_val | input | 32 | Register value read for the rs field |
| rt_val | input | 32 | Register value read for the rt field |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address that will load on the next edge |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index, 31 when requested |
| link_val | output | 32 | Return address, PC+8 when requested |

## Verification
The call jump is the one instruction where redirection and the link write happen together, and the two use different arithmetic on the same PC: the target takes its top nibble from PC+4 while the return address is PC+8. The bench provokes this by first steering the PC through a register jump to 0x0FFFFFFC, so that PC+4 crosses into a new 256 MB region, then issuing the call; both the link outputs sampled before the edge and the PC loaded after it are compared with values computed from the requirements. Random traffic mixes calls with every other control form so that stale link outputs on a non-call cycle are also caught.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int unsigned LINK_REG = 31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] pc_next,
  output logic        link_we,
  output logic [4:0]  link_idx,
  output logic [31:0] link_val
);
  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_REGIMM  = 6'h01;
  localparam logic [5:0] OP_JMP     = 6'h02;
  localparam logic [5:0] OP_CALL    = 6'h03;
  localparam logic [5:0] OP_EQ      = 6'h04;
  localparam logic [5:0] OP_NE      = 6'h05;
  localparam logic [5:0] OP_LEZ     = 6'h06;
  localparam logic [5:0] OP_GTZ     = 6'h07;
  localparam logic [5:0] FN_REGJMP  = 6'h08;

  logic [31:0] pc_q;
  logic [5:0]  op, fn;
  logic [4:0]  sub;
  logic [31:0] seq, br_tgt, jmp_tgt;
  logic        neg, zero, taken;

  assign op  = instr[31:26];
  assign fn  = instr[5:0];
  assign sub = instr[20:16];

  assign seq     = pc_q + 32'd4;
  assign br_tgt  = seq + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_tgt = {seq[31:28], instr[25:0], 2'b00};

  assign neg  = rs_val[31];
  assign zero = (rs_val == 32'd0);

  always_comb begin
    taken = 1'b0;
    case (op)
      OP_REGIMM: taken = (sub == 5'd0) ? neg : ((sub == 5'd1) ? !neg : 1'b0);
      OP_EQ:     taken = (rs_val == rt_val);
      OP_NE:     taken = (rs_val != rt_val);
      OP_LEZ:    taken = neg || zero;
      OP_GTZ:    taken = !neg && !zero;
      default:   taken = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      OP_SPECIAL:    pc_next = (fn == FN_REGJMP) ? rs_val : seq;
      OP_JMP,
      OP_CALL:       pc_next = jmp_tgt;
      OP_REGIMM,
      OP_EQ, OP_NE,
      OP_LEZ,
      OP_GTZ:        pc_next = taken ? br_tgt : seq;
      default:       pc_next = seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= 32'd0;
    else     pc_q <= pc_next;
  end

  assign pc       = pc_q;
  assign link_we  = (op == OP_CALL);
  assign link_idx = link_we ? 5'(LINK_REG) : 5'd0;
  assign link_val = link_we ? pc_q + 32'd8 : 32'd0;
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] pc,
  input logic        link_we,
  input logic [4:0]  link_idx
);
  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:29] != 3'b000) |=> (pc == $past(pc) + 32'd4));

  // R3
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h02) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

  // R4
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h00 && instr[5:0] == 6'h08) |=> (pc == $past(rs_val)));

  // R5
  eq_fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h04 && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4));

  // R8
  call_link_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h03) |-> (link_we && link_idx == 5'd31));

  // R9
  no_link_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != 6'h03) |-> (!link_we && link_idx == 5'd0));
endmodule

bind next_pc_unit next_pc_unit_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
  .pc(pc), .link_we(link_we), .link_idx(link_idx)
);

// File: tb/tb_next_pc_unit.sv
`timescale 1ns/1ps
module tb_next_pc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'd0, rs_val = 32'd0, rt_val = 32'd0;
  logic [31:0] pc, pc_next, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m_pc = 32'd0;

  always #2 clk = ~clk;

  next_pc_unit dut (
    .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .pc_next(pc_next), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val)
  );

  function automatic logic [31:0] model_next(logic [31:0] p, logic [31:0] ins,
                                             logic [31:0] a, logic [31:0] b);
    logic [31:0] p4, bt, jt;
    logic        t;
    p4 = p + 32'd4;
    bt = p4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    jt = {p4[31:28], ins[25:0], 2'b00};
    t  = 1'b0;
    case (ins[31:26])
      6'h00: return (ins[5:0] == 6'h08) ? a : p4;
      6'h01: t = (ins[20:16] == 5'd0) ? $signed(a) < 0 :
                 (ins[20:16] == 5'd1) ? $signed(a) >= 0 : 1'b0;
      6'h02, 6'h03: return jt;
      6'h04: t = (a == b);
      6'h05: t = (a != b);
      6'h06: t = ($signed(a) <= 0);
      6'h07: t = ($signed(a) > 0);
      default: return p4;
    endcase
    return t ? bt : p4;
  endfunction

  function automatic string req_of(logic [31:0] ins);
    case (ins[31:26])
      6'h00: return (ins[5:0] == 6'h08) ? "R4" : "R2";
      6'h01: return "R6";
      6'h02: return "R3";
      6'h03: return "R8";
      6'h04, 6'h05: return "R5";
      6'h06, 6'h07: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    bit call;
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = b;
    #1;
    call = (ins[31:26] == 6'h03);
    if (call) begin
      chk("R8", {31'd0, link_we}, 32'd1);
      chk("R8", {27'd0, link_idx}, 32'd31);
      chk("R8", link_val, m_pc + 32'd8);
    end else begin
      chk("R9", {26'd0, link_idx, link_we}, 32'd0);
      chk("R9", link_val, 32'd0);
    end
    @(posedge clk); #1;
    m_pc = model_next(m_pc, ins, a, b);
    chk(req_of(ins), pc, m_pc);
  endtask

  task automatic set_pc(logic [31:0] v);
    step(32'h0000_0008, v, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    #1;
    chk("R1", pc, 32'd0);
    @(negedge clk); rst = 1'b0;
    m_pc = 32'd0;

    // directed corner cases
    set_pc(32'h0000_0100);
    step({6'h04, 5'd5, 5'd1, 16'd3}, 32'd7, 32'd7);           // R5 taken +12 -> 0x110
    chk("R5", pc, 32'h0000_0110);
    step({6'h05, 5'd5, 5'd1, 16'hFFFE}, 32'd1, 32'd2);        // R5 negative offset
    step({6'h04, 5'd5, 5'd1, 16'h0040}, 32'd1, 32'd2);        // R5 not taken
    step({6'h06, 5'd5, 5'd0, 16'd4}, 32'd0, 32'd0);           // R7 zero is <= 0
    step({6'h07, 5'd5, 5'd0, 16'd4}, 32'd0, 32'd0);           // R7 zero not > 0
    step({6'h01, 5'd5, 5'd0, 16'd8}, 32'h8000_0000, 32'd0);   // R6 most negative
    step({6'h01, 5'd5, 5'd1, 16'd8}, 32'd0, 32'd0);           // R6 zero is >= 0
    step({6'h01, 5'd5, 5'd2, 16'd8}, 32'h8000_0000, 32'd0);   // R6 other subcode
    step({6'h00, 5'd3, 15'd0, 6'h09}, 32'h1234_5678, 32'd0);  // R2 funct not 0x08
    set_pc(32'h0FFF_FFFC);
    step({6'h03, 26'h000_0001}, 32'd0, 32'd0);                // R8 region crossing
    chk("R8", pc, 32'h1000_0004);
    set_pc(32'hF000_0000);
    step({6'h02, 26'h3FF_FFFF}, 32'd0, 32'd0);                // R3
    chk("R3", pc, 32'hFFFF_FFFC);
    step(32'hFC00_0000, 32'd0, 32'd0);                        // R2 wrap
    chk("R2", pc, 32'd0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins, a, b;
      int unsigned sel;
      ins = $urandom();
      sel = $urandom_range(0, 9);
      if (sel <= 7) ins[31:26] = 6'(sel);
      if (sel == 0 && $urandom_range(0, 1) == 1) ins[5:0] = 6'h08;
      if (sel == 1) ins[20:16] = 5'($urandom_range(0, 2));
      a = $urandom();
      case ($urandom_range(0, 3))
        0: a = 32'd0;
        1: a = {a[31], 31'd0};
        default: ;
      endcase
      b = ($urandom_range(0, 1) == 1) ? a : $urandom();
      step(ins, a, b);
    end

    // R1 reset mid-run, synchronous
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", pc, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule